// File: doc/BRIEF.md
# Message-Signalled Interrupt Collector

This block gathers message-signalled interrupt payloads that arrive as plain memory-mapped writes. It stores them in a parameterised set of address slots. Each slot is a first-in first-out queue of 32-bit words. While a slot holds anything unread and its mask bit is clear, the block raises a single level interrupt toward a host processor. The host then reads a slot's address to pop the oldest payload.

The agent port has a write channel and a read channel, and both complete in a fixed number of cycles. A write is taken in the cycle it is presented and is never stalled. A read returns its data exactly one cycle after the request. When a slot's queue is already full, any further write to that slot is dropped. The drop is recorded in a per-slot sticky flag and in a saturating 16-bit counter. The host clears both by writing a one to the flag.

With N slots the word map is as follows:
- Offsets 0 to N-1: the slot queues.
- Offset N: the read-only status word.
- Offset N+1: the mask word, readable and writable.
- Offset N+2: the overflow flags, cleared by writing a one.
- Offsets N+3 to 2N+2: the drop counters, one per slot, read-only.

Top module: `msi_collector`

## Requirements
- R1: After reset, the status, mask and overflow words read as zero. All drop counters read as zero, `irq` is low and `rdValid` is low.
- R2: A write to offset i (i < N) appends `wrData` to slot i. Reads of offset i return the slot's entries oldest first. Each read's data appears on `rdData`, with `rdValid` high, exactly one cycle after the `rdEn` cycle, and `rdValid` is low in any cycle that does not follow a read.
- R3: A read of an empty slot returns zero and leaves the slot, its status bit and all other state unchanged.
- R4: Bit i of the status word (offset N) is 1 exactly when slot i holds at least one unread entry. Bits at positions N and above read as 0.
- R5: The mask word (offset N+1) takes the low N bits of a write. A mask bit of 1 blocks its slot. `irq` is high exactly when some slot has status 1 and mask 0, and it stays high until such slots are drained or masked.
- R6: Each slot holds QUEUE_DEPTH entries (default 32). A write to a full slot is discarded and leaves the queued entries intact. A full slot discards a write even when the same cycle also reads that slot.
- R7: Each discarded write sets bit i of the overflow word (offset N+2). It also increments slot i's drop counter (offset N+3+i), which stops at 65535.
- R8: Writing offset N+2 clears the flag and the counter of every slot whose data bit is 1. Slots whose data bit is 0 are left as they were.
- R9: A write and a read to the same slot in one cycle, on a slot that is not full, push and pop together. The occupancy stays the same and the read returns the oldest entry already present. If the slot was empty, the read returns zero and the new entry stays queued.
- R10: Writes to the status word, to the counters, or beyond offset 2N+2 change nothing. Reads beyond offset 2N+2 return zero.
- R11: A register read returns the value held before any write to that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request, accepted in the same cycle |
| wrAddr | input | ADDR_W | Word offset of the write |
| wrData | input | DATA_W | Write payload or register value |
| rdEn | input | 1 | Read request |
| rdAddr | input | ADDR_W | Word offset of the read |
| rdData | output | DATA_W | Read result, one cycle after the request |
| rdValid | output | 1 | High in the cycle that `rdData` is valid |
| irq | output | 1 | Level interrupt: some unmasked slot is not empty |

## Verification
The interrupt logic is swept exhaustively on a four-slot build. Every combination of non-empty slots is paired with every mask value, which separates a wrong polarity from a wrong bit position in the gating. Queue order is checked with fills of differing lengths per slot, so that any mixing of pointers between slots shows up. A queue is filled to its limit and then written past it, and a later drain of that queue separates correctly dropped writes from overwritten entries. Same-cycle write and read pairs on full, partly filled and empty slots separate the push-and-pop path from plain push and plain pop. The saturation limit of the drop counter is reached with more than 65535 discarded writes.

// File: rtl/msi_collector_pkg.sv
package msi_collector_pkg;
  localparam int MAX_SLOTS = 32;

  typedef enum logic [2:0] {
    RD_NONE, RD_SLOT, RD_STATUS, RD_MASK, RD_STICKY, RD_COUNT
  } rdKind_e;

  typedef struct packed {
    logic [MAX_SLOTS-1:0] push;
    logic [MAX_SLOTS-1:0] pop;
    logic [MAX_SLOTS-1:0] drop;
    logic                 maskWe;
    logic                 clrWe;
    logic                 rdReq;
    rdKind_e              rdKind;
    logic [4:0]           rdIdx;
  } strobes_t;
endpackage

// File: rtl/msi_collector_ctrl.sv
module msi_collector_ctrl
  import msi_collector_pkg::*;
#(
  parameter int SLOT_COUNT = 4,
  parameter int ADDR_W     = 4
) (
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [SLOT_COUNT-1:0] notEmpty,
  input  logic [SLOT_COUNT-1:0] full,
  output strobes_t              st
);
  localparam logic [ADDR_W-1:0] STATUS_OFS = ADDR_W'(SLOT_COUNT);
  localparam logic [ADDR_W-1:0] MASK_OFS   = ADDR_W'(SLOT_COUNT + 1);
  localparam logic [ADDR_W-1:0] STICKY_OFS = ADDR_W'(SLOT_COUNT + 2);
  localparam logic [ADDR_W-1:0] COUNT_OFS  = ADDR_W'(SLOT_COUNT + 3);
  localparam logic [ADDR_W-1:0] END_OFS    = ADDR_W'(2 * SLOT_COUNT + 3);

  always_comb begin
    st = '0;
    // write channel: slot pushes, drops and register writes
    if (wrEn) begin
      if (wrAddr < STATUS_OFS) begin
        for (int i = 0; i < SLOT_COUNT; i++) begin
          if (wrAddr == ADDR_W'(i)) begin
            if (full[i]) st.drop[i] = 1'b1;
            else         st.push[i] = 1'b1;
          end
        end
      end else if (wrAddr == MASK_OFS) begin
        st.maskWe = 1'b1;
      end else if (wrAddr == STICKY_OFS) begin
        st.clrWe = 1'b1;
      end
    end
    // read channel: pop on non-empty slot, register select otherwise
    st.rdReq = rdEn;
    if (rdEn) begin
      if (rdAddr < STATUS_OFS) begin
        st.rdKind = RD_SLOT;
        st.rdIdx  = 5'(rdAddr);
        for (int i = 0; i < SLOT_COUNT; i++) begin
          if (rdAddr == ADDR_W'(i) && notEmpty[i]) st.pop[i] = 1'b1;
        end
      end else if (rdAddr == STATUS_OFS) begin
        st.rdKind = RD_STATUS;
      end else if (rdAddr == MASK_OFS) begin
        st.rdKind = RD_MASK;
      end else if (rdAddr == STICKY_OFS) begin
        st.rdKind = RD_STICKY;
      end else if (rdAddr < END_OFS) begin
        st.rdKind = RD_COUNT;
        st.rdIdx  = 5'(rdAddr - COUNT_OFS);
      end
    end
  end
endmodule

// File: rtl/msi_collector_dp.sv
module msi_collector_dp
  import msi_collector_pkg::*;
#(
  parameter int SLOT_COUNT  = 4,
  parameter int QUEUE_DEPTH = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              st,
  input  logic [DATA_W-1:0]     wrData,
  output logic [SLOT_COUNT-1:0] notEmpty,
  output logic [SLOT_COUNT-1:0] full,
  output logic [SLOT_COUNT-1:0] maskVec,
  output logic [SLOT_COUNT-1:0] stickyVec,
  output logic [DATA_W-1:0]     rdData,
  output logic                  rdValid
);
  localparam int PTR_W = $clog2(QUEUE_DEPTH);
  localparam logic [PTR_W:0] FULL_LEVEL = (PTR_W+1)'(QUEUE_DEPTH);

  logic [DATA_W-1:0] headWord [SLOT_COUNT];
  logic [CNT_W-1:0]  dropCnt  [SLOT_COUNT];
  logic [DATA_W-1:0] rdNext;

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : gSlot
    logic [DATA_W-1:0] store [QUEUE_DEPTH];
    logic [PTR_W-1:0]  wrPtr, rdPtr;
    logic [PTR_W:0]    occ;
    logic              stickyBit;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        occ   <= '0;
      end else begin
        if (st.push[s]) wrPtr <= wrPtr + 1'b1;
        if (st.pop[s])  rdPtr <= rdPtr + 1'b1;
        if (st.push[s] && !st.pop[s])      occ <= occ + 1'b1;
        else if (!st.push[s] && st.pop[s]) occ <= occ - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (st.push[s]) store[wrPtr] <= wrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stickyBit <= 1'b0;
        cnt       <= '0;
      end else if (st.clrWe && wrData[s]) begin
        stickyBit <= 1'b0;
        cnt       <= '0;
      end else if (st.drop[s]) begin
        stickyBit <= 1'b1;
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end

    assign headWord[s]  = store[rdPtr];
    assign notEmpty[s]  = (occ != '0);
    assign full[s]      = (occ == FULL_LEVEL);
    assign stickyVec[s] = stickyBit;
    assign dropCnt[s]   = cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          maskVec <= '0;
    else if (st.maskWe) maskVec <= wrData[SLOT_COUNT-1:0];
  end

  always_comb begin
    rdNext = '0;
    case (st.rdKind)
      RD_SLOT: begin
        for (int i = 0; i < SLOT_COUNT; i++) begin
          if (st.rdIdx == 5'(i) && notEmpty[i]) rdNext = headWord[i];
        end
      end
      RD_STATUS: rdNext = DATA_W'(notEmpty);
      RD_MASK:   rdNext = DATA_W'(maskVec);
      RD_STICKY: rdNext = DATA_W'(stickyVec);
      RD_COUNT: begin
        for (int i = 0; i < SLOT_COUNT; i++) begin
          if (st.rdIdx == 5'(i)) rdNext = DATA_W'(dropCnt[i]);
        end
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdData  <= st.rdReq ? rdNext : '0;
      rdValid <= st.rdReq;
    end
  end
endmodule

// File: rtl/msi_collector.sv
module msi_collector
  import msi_collector_pkg::*;
#(
  parameter int SLOT_COUNT  = 4,
  parameter int QUEUE_DEPTH = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 16,
  localparam int ADDR_W     = $clog2(2 * SLOT_COUNT + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              irq
);
  strobes_t              st;
  logic [SLOT_COUNT-1:0] statusVec;
  logic [SLOT_COUNT-1:0] fullVec;
  logic [SLOT_COUNT-1:0] maskVec;
  logic [SLOT_COUNT-1:0] stickyVec;

  msi_collector_ctrl #(.SLOT_COUNT(SLOT_COUNT), .ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdEn(rdEn), .rdAddr(rdAddr),
    .notEmpty(statusVec), .full(fullVec), .st(st)
  );

  msi_collector_dp #(
    .SLOT_COUNT(SLOT_COUNT), .QUEUE_DEPTH(QUEUE_DEPTH),
    .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .st(st), .wrData(wrData),
    .notEmpty(statusVec), .full(fullVec), .maskVec(maskVec),
    .stickyVec(stickyVec), .rdData(rdData), .rdValid(rdValid)
  );

  assign irq = |(statusVec & ~maskVec);
endmodule

// File: rtl/msi_collector_chk.sv
module msi_collector_chk #(
  parameter int SLOT_COUNT = 4,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     rdAddr,
  input logic [DATA_W-1:0]     rdData,
  input logic                  rdValid,
  input logic                  irq,
  input logic [SLOT_COUNT-1:0] statusVec,
  input logic [SLOT_COUNT-1:0] maskVec,
  input logic [SLOT_COUNT-1:0] stickyVec,
  input logic [SLOT_COUNT-1:0] fullVec
);
  localparam logic [ADDR_W-1:0] N_ADDR = ADDR_W'(SLOT_COUNT);

  logic [SLOT_COUNT-1:0] wrSel, rdSel;
  assign wrSel = (wrEn && wrAddr < N_ADDR) ? (SLOT_COUNT'(1) << wrAddr) : '0;
  assign rdSel = (rdEn && rdAddr < N_ADDR) ? (SLOT_COUNT'(1) << rdAddr) : '0;

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel != '0 && (statusVec & rdSel) == '0) |=> rdData == '0);

  assert_status_needs_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel == '0) |=> (statusVec & ~$past(statusVec)) == '0);

  assert_status_idle_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && !rdEn) |=> $stable(statusVec));

  assert_irq_all_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '1) |-> !irq);

  assert_irq_rise_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(wrEn));

  assert_full_stays_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((fullVec & wrSel) != '0 && !rdEn) |=> (fullVec & $past(wrSel)) != '0);

  assert_drop_logged_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((fullVec & wrSel) != '0) |=> (stickyVec & $past(wrSel)) != '0);
endmodule

bind msi_collector msi_collector_chk #(
  .SLOT_COUNT(SLOT_COUNT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) uChk (.*);

// File: tb/msi_collector_test.sv
`timescale 1ns/1ps
module msi_collector_test;
  localparam int N  = 4;
  localparam int QD = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_STATUS = 4'd4;
  localparam logic [AW-1:0] A_MASK   = 4'd5;
  localparam logic [AW-1:0] A_STICKY = 4'd6;
  localparam logic [AW-1:0] A_COUNT0 = 4'd7;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [31:0]   wrData = '0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [31:0]   rdData;
  logic          rdValid;
  logic          irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  msi_collector #(.SLOT_COUNT(N), .QUEUE_DEPTH(QD)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid), .irq(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 180000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<180000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(logic [AW-1:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(logic [AW-1:0] a, output logic [31:0] d);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
    check("R2 rdValid one cycle after read", 32'(rdValid), 32'd1);
  endtask

  task automatic readCheck(string tag, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] d;
    doRead(a, d);
    check(tag, d, exp);
  endtask

  task automatic doBoth(logic [AW-1:0] wa, logic [31:0] wd, logic [AW-1:0] ra,
                        output logic [31:0] d);
    wrEn = 1'b1; wrAddr = wa; wrData = wd; rdEn = 1'b1; rdAddr = ra;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    d = rdData;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq after reset", 32'(irq), 32'd0);
    check("R1 rdValid after reset", 32'(rdValid), 32'd0);
    readCheck("R1 status after reset", A_STATUS, 32'd0);
    readCheck("R1 mask after reset", A_MASK, 32'd0);
    readCheck("R1 sticky after reset", A_STICKY, 32'd0);
    for (int i = 0; i < N; i++) readCheck("R1 counter after reset", A_COUNT0 + AW'(i), 32'd0);
    @(negedge clk);
    check("R2 rdValid low without read", 32'(rdValid), 32'd0);

    // R2/R4: different fill lengths per slot, FIFO order
    for (int s = 0; s < N; s++)
      for (int k = 0; k <= s; k++) doWrite(AW'(s), 32'hA000_0000 + 32'(s * 256 + k));
    readCheck("R4 status all non-empty", A_STATUS, 32'hF);
    check("R5 irq with unmasked entries", 32'(irq), 32'd1);
    for (int s = 0; s < N; s++) begin
      for (int k = 0; k <= s; k++)
        readCheck("R2 fifo order", AW'(s), 32'hA000_0000 + 32'(s * 256 + k));
      readCheck("R4 status after drain", A_STATUS, 32'hF & ~((32'd2 << s) - 32'd1));
    end
    check("R5 irq low once drained", 32'(irq), 32'd0);
    readCheck("R3 empty slot read zero", 4'd1, 32'd0);
    readCheck("R3 status unchanged by empty read", A_STATUS, 32'd0);

    // R5: exhaustive status x mask sweep
    for (int sp = 0; sp < 16; sp++) begin
      for (int s = 0; s < N; s++) if (sp[s]) doWrite(AW'(s), 32'(sp));
      readCheck("R4 status pattern", A_STATUS, 32'(sp));
      for (int m = 0; m < 16; m++) begin
        doWrite(A_MASK, 32'hFFFF_FFF0 | 32'(m));
        check("R5 irq gating", 32'(irq), 32'(((sp & ~m) & 15) != 0));
      end
      readCheck("R5 mask readback", A_MASK, 32'hF);
      for (int s = 0; s < N; s++) if (sp[s]) readCheck("R2 sweep drain", AW'(s), 32'(sp));
      doWrite(A_MASK, 32'd0);
    end

    // R6/R7: overflow slot 1
    for (int k = 0; k < QD; k++) doWrite(4'd1, 32'hB100_0000 + 32'(k));
    doWrite(4'd1, 32'hDEAD_0000);
    readCheck("R7 sticky after drop", A_STICKY, 32'h2);
    readCheck("R7 counter after drop", A_COUNT0 + 4'd1, 32'd1);
    for (int k = 0; k < 3; k++) doWrite(4'd1, 32'hDEAD_0001 + 32'(k));
    readCheck("R7 counter after four drops", A_COUNT0 + 4'd1, 32'd4);
    readCheck("R7 other counter untouched", A_COUNT0, 32'd0);
    // R6: full slot with simultaneous read still drops the write
    doBoth(4'd1, 32'hDEAD_0009, 4'd1, got);
    check("R6 pop on full slot", got, 32'hB100_0000);
    readCheck("R6 drop despite same-cycle read", A_COUNT0 + 4'd1, 32'd5);
    for (int k = 1; k < QD; k++) readCheck("R6 contents intact", 4'd1, 32'hB100_0000 + 32'(k));
    readCheck("R6 slot empty after drain", 4'd1, 32'd0);

    // R8: selective clear
    doWrite(A_STICKY, 32'h1);
    readCheck("R8 zero bit keeps sticky", A_STICKY, 32'h2);
    readCheck("R8 zero bit keeps counter", A_COUNT0 + 4'd1, 32'd5);
    doWrite(A_STICKY, 32'h2);
    readCheck("R8 sticky cleared", A_STICKY, 32'h0);
    readCheck("R8 counter cleared", A_COUNT0 + 4'd1, 32'd0);

    // R9: same-cycle push and pop
    doWrite(4'd0, 32'h1111_0001);
    doWrite(4'd0, 32'h1111_0002);
    doBoth(4'd0, 32'h1111_0003, 4'd0, got);
    check("R9 simultaneous returns oldest", got, 32'h1111_0001);
    readCheck("R9 next entry", 4'd0, 32'h1111_0002);
    readCheck("R9 pushed entry kept", 4'd0, 32'h1111_0003);
    readCheck("R9 occupancy unchanged then empty", 4'd0, 32'd0);
    doBoth(4'd2, 32'h2222_0001, 4'd2, got);
    check("R9 empty simultaneous read zero", got, 32'd0);
    readCheck("R9 entry stays queued", A_STATUS, 32'h4);
    readCheck("R9 queued entry readable", 4'd2, 32'h2222_0001);

    // R10: ignored writes, out-of-range reads
    doWrite(A_STATUS, 32'hF);
    readCheck("R10 status write ignored", A_STATUS, 32'd0);
    check("R10 irq unaffected by status write", 32'(irq), 32'd0);
    doWrite(A_COUNT0 + 4'd2, 32'd5);
    readCheck("R10 counter write ignored", A_COUNT0 + 4'd2, 32'd0);
    doWrite(4'd15, 32'hFFFF_FFFF);
    readCheck("R10 mask untouched by stray write", A_MASK, 32'd0);
    readCheck("R10 out-of-range read zero", 4'd15, 32'd0);
    readCheck("R10 first unused offset zero", 4'd11, 32'd0);

    // R11: read sees value before same-cycle write
    doWrite(A_MASK, 32'h5);
    doBoth(A_MASK, 32'hA, A_MASK, got);
    check("R11 old mask on same-cycle read", got, 32'h5);
    readCheck("R11 new mask after", A_MASK, 32'hA);
    doWrite(A_MASK, 32'h0);

    // R7: counter saturation on slot 3
    for (int k = 0; k < QD; k++) doWrite(4'd3, 32'(k));
    for (int k = 0; k < 65540; k++) doWrite(4'd3, 32'hCAFE_0000);
    readCheck("R7 counter saturates", A_COUNT0 + 4'd3, 32'd65535);
    doWrite(A_STICKY, 32'h8);
    readCheck("R8 saturated counter cleared", A_COUNT0 + 4'd3, 32'd0);
    readCheck("R6 head intact after many drops", 4'd3, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule